// File: doc/BRIEF.md
# Clock Multiplier Change Sequencer

This block owns the multiplication factor that a clock generator applies to its reference, and decides when a factor that software requests becomes live. Software issues a single write that carries a 2-bit target factor, a mode bit, and a 3-bit settling-time select. With the mode bit clear, the target is only held. It becomes live during the next standby: first the system clock is gated off, then the held target is made active. After a wake event, a settling count must expire before the clock is released again. With the mode bit set, the target becomes active right after the write, with no standby.

The multiplied clock itself is not modelled. The block reports the active factor as a one-hot value (1, 2 or 4) that downstream clock logic consumes. It also drives a clock-enable for the system clock and a ready flag. All logic runs on the always-running reference clock. Writes and standby requests are taken only while the block is running; the bus master is halted at all other times.

Top module: `clk_mult_seq`

## Requirements
- R1: After synchronous reset the active factor output is 3'b001 (×1), and both clock enable and ready are 1.
- R2: Target code 00 selects ×1 (factor 3'b001), 01 selects ×2 (3'b010) and 10 selects ×4 (3'b100). A write of code 11 leaves the held target and the active factor unchanged.
- R3: A write with mode bit 0 does not change the active factor while the block is running.
- R4: When several mode-0 writes precede a standby request, the target of the last legal write is the one applied.
- R5: At the reference edge that samples the standby request, the clock enable goes low and the factor keeps its old value. One edge later, the held target becomes the active factor.
- R6: With settle select n, the wake edge opens a settling interval of 2^(9+n) reference cycles. Clock enable and ready are still 0 after the edge 2^(9+n)−1 edges past the wake edge. Both are 1 after the edge 2^(9+n) edges past it.
- R7: Ready is 0 from standby entry until the settling count expires, and 1 at all other times. During standby the clock enable matches ready.
- R8: A write with mode bit 1 and a legal target changes the active factor at the edge that samples the write. Clock enable and ready stay 1.
- R9: A wake event that arrives before the clock has finished stopping, including one in the same cycle as the standby request, is held. Settling then starts once the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_imm | input | 1 | Mode bit of the write: 1 applies the target at once, 0 defers it to standby |
| cfg_target | input | 2 | Target factor code (00 ×1, 01 ×2, 10 ×4, 11 reserved) |
| cfg_settle | input | 3 | Settling select n; interval is 2^(9+n) reference cycles |
| sby_req | input | 1 | Standby request strobe |
| wake | input | 1 | Wake event |
| mult_factor | output | 3 | Active factor, one-hot: 001 ×1, 010 ×2, 100 ×4 |
| sys_clk_en | output | 1 | Gate enable for the system clock |
| ready | output | 1 | High when running at a settled factor |

## Verification
The hardest case to reach is a wake event that lands while standby is still being entered. The clock is gated, but the held factor has not yet been applied and the block is not yet waiting for wake. The stimulus asserts wake in the same cycle as the standby request and then releases it. The result is then observed at the ports: the settling interval must begin two edges later, and ready must return after exactly the programmed count. The exact-count checks at both the last low cycle and the first high cycle fix the interval length to a single cycle for two different selects.

// File: rtl/cms_pkg.sv
package cms_pkg;

    parameter int SETTLE_BASE = 9;
    parameter int SEL_W       = 3;

    typedef enum logic [1:0] {
        TGT_X1   = 2'b00,
        TGT_X2   = 2'b01,
        TGT_X4   = 2'b10,
        TGT_RSVD = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_STOP,
        ST_SLEEP,
        ST_SETTLE
    } seq_st_e;

    function automatic logic tgt_legal(input tgt_e t);
        return t != TGT_RSVD;
    endfunction

    function automatic logic [2:0] factor_of(input tgt_e t);
        case (t)
            TGT_X2:  return 3'b010;
            TGT_X4:  return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

endpackage

// File: rtl/cms_cfg_regs.sv
module cms_cfg_regs
    import cms_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          accept,
    input  tgt_e          wr_tgt,
    input  logic [SW-1:0] wr_sel,
    output tgt_e          tgt_q,
    output logic [SW-1:0] sel_q
);

    logic take;
    assign take = wr_en && accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q <= TGT_X1;
            sel_q <= '0;
        end else if (take) begin
            sel_q <= wr_sel;
            if (tgt_legal(wr_tgt)) tgt_q <= wr_tgt;
        end
    end

    AST_RSVD_KEEPS_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_tgt == TGT_RSVD) |=> $stable(tgt_q)) // R2
        else $error("reserved code altered held target");

endmodule

// File: rtl/cms_settle_timer.sv
module cms_settle_timer #(
    parameter int BASE = 9,
    parameter int SW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [SW-1:0] sel,
    output logic          busy,
    output logic          done
);

    localparam int CNT_W = BASE + (1 << SW) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] load;

    assign span = (CNT_W + 1)'(1) << (BASE + int'(sel));
    assign load = CNT_W'(span - 1'b1);
    assign done = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= load;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_COUNT_STEPS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - 1'b1)) // R6
        else $error("settle counter skipped");

endmodule

// File: rtl/cms_seq_ctrl.sv
module cms_seq_ctrl
    import cms_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sby_req,
    input  logic wake,
    input  logic wr_en,
    input  logic wr_imm,
    input  tgt_e wr_tgt,
    input  tgt_e held_tgt,
    input  logic timer_done,
    output tgt_e active,
    output logic running,
    output logic timer_start
);

    seq_st_e st;
    logic    pend;

    assign running     = (st == ST_RUN);
    assign timer_start = (st == ST_SLEEP) && (pend || wake);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_RUN;
            active <= TGT_X1;
            pend   <= 1'b0;
        end else begin
            case (st)
                ST_RUN: begin
                    if (wr_en && wr_imm && tgt_legal(wr_tgt)) active <= wr_tgt;
                    if (sby_req) begin
                        st   <= ST_STOP;
                        pend <= wake;
                    end
                end
                ST_STOP: begin
                    st     <= ST_SLEEP;
                    active <= held_tgt;
                    pend   <= pend || wake;
                end
                ST_SLEEP: begin
                    if (pend || wake) begin
                        st   <= ST_SETTLE;
                        pend <= 1'b0;
                    end
                end
                default: begin
                    if (timer_done) st <= ST_RUN;
                end
            endcase
        end
    end

    AST_FACTOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        active != TGT_RSVD) // R2
        else $error("reserved factor active");

    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && !(wr_en && wr_imm)) |=> $stable(active)) // R3
        else $error("deferred write changed factor");

    AST_GATE_BEFORE_APPLY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && sby_req) |=> (!running && $stable(active))) // R5
        else $error("factor changed before clock gated");

    AST_EARLY_WAKE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP && wake) |=> pend) // R9
        else $error("early wake dropped");

endmodule

// File: rtl/clk_mult_seq.sv
module clk_mult_seq
    import cms_pkg::*;
#(
    parameter int BASE = SETTLE_BASE,
    parameter int SW   = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic          cfg_imm,
    input  logic [1:0]    cfg_target,
    input  logic [SW-1:0] cfg_settle,
    input  logic          sby_req,
    input  logic          wake,
    output logic [2:0]    mult_factor,
    output logic          sys_clk_en,
    output logic          ready
);

    tgt_e          wr_tgt;
    tgt_e          held_tgt;
    tgt_e          active;
    logic [SW-1:0] sel_q;
    logic          running;
    logic          t_start;
    logic          t_busy;
    logic          t_done;

    assign wr_tgt = tgt_e'(cfg_target);

    cms_cfg_regs #(.SW(SW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr),
        .accept (running),
        .wr_tgt (wr_tgt),
        .wr_sel (cfg_settle),
        .tgt_q  (held_tgt),
        .sel_q  (sel_q)
    );

    cms_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sby_req     (sby_req),
        .wake        (wake),
        .wr_en       (cfg_wr),
        .wr_imm      (cfg_imm),
        .wr_tgt      (wr_tgt),
        .held_tgt    (held_tgt),
        .timer_done  (t_done),
        .active      (active),
        .running     (running),
        .timer_start (t_start)
    );

    cms_settle_timer #(.BASE(BASE), .SW(SW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (t_start),
        .sel   (sel_q),
        .busy  (t_busy),
        .done  (t_done)
    );

    assign mult_factor = factor_of(active);
    assign sys_clk_en  = running;
    assign ready       = running;

    AST_NOT_READY_SETTLING: assert property (@(posedge clk) disable iff (rst)
        t_busy |-> (!ready && !sys_clk_en)) // R7
        else $error("ready while settling");

endmodule

// File: tb/test_clk_mult_seq.sv
module test_clk_mult_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic       cfg_imm = 1'b0;
    logic [1:0] cfg_target = 2'b00;
    logic [2:0] cfg_settle = 3'd0;
    logic       sby_req = 1'b0;
    logic       wake = 1'b0;
    logic [2:0] mult_factor;
    logic       sys_clk_en;
    logic       ready;

    always #2.5 clk = ~clk;

    clk_mult_seq i_clk_mult_seq (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_imm     (cfg_imm),
        .cfg_target  (cfg_target),
        .cfg_settle  (cfg_settle),
        .sby_req     (sby_req),
        .wake        (wake),
        .mult_factor (mult_factor),
        .sys_clk_en  (sys_clk_en),
        .ready       (ready)
    );

    typedef struct {
        logic [2:0] f;
        logic       ce;
        logic       rd;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   finished = 0;

    // monitor: compares every queued expectation at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (mult_factor !== e.f || sys_clk_en !== e.ce || ready !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s: actual f=%b ce=%b rdy=%b expected f=%b ce=%b rdy=%b",
                             e.tag, mult_factor, sys_clk_en, ready, e.f, e.ce, e.rd);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic [2:0] f, input logic ce, input logic rd, input string tag);
        exp_t e;
        e.f = f; e.ce = ce; e.rd = rd; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_write(input logic imm, input logic [1:0] tgt, input logic [2:0] sel);
        cfg_wr = 1'b1; cfg_imm = imm; cfg_target = tgt; cfg_settle = sel;
        tick();
        cfg_wr = 1'b0; cfg_imm = 1'b0;
    endtask

    // run a settling window whose first edge has just passed
    task automatic settle_rest(input int span, input logic [2:0] f, input string tag);
        for (int k = 1; k < span; k++) tick();
        expect_out(f, 1'b0, 1'b0, tag);
        tick();
        expect_out(f, 1'b1, 1'b1, tag);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        expect_out(3'b001, 1'b1, 1'b1, "R1 reset state");

        // deferred writes: no effect while running
        do_write(1'b0, 2'b01, 3'd0);
        expect_out(3'b001, 1'b1, 1'b1, "R3 deferred x2 write");
        do_write(1'b0, 2'b10, 3'd0);
        expect_out(3'b001, 1'b1, 1'b1, "R3 deferred x4 write");
        do_write(1'b0, 2'b11, 3'd0);
        expect_out(3'b001, 1'b1, 1'b1, "R2 reserved write while running");

        // standby entry: gate first, then apply (latest legal = x4)
        sby_req = 1'b1;
        tick();
        sby_req = 1'b0;
        expect_out(3'b001, 1'b0, 1'b0, "R5 gated with old factor");
        tick();
        expect_out(3'b100, 1'b0, 1'b0, "R4 latest target applied");
        repeat (5) tick();
        expect_out(3'b100, 1'b0, 1'b0, "R7 low while waiting wake");

        // wake with select 0: 512 cycles
        wake = 1'b1;
        tick();
        wake = 1'b0;
        expect_out(3'b100, 1'b0, 1'b0, "R7 low at settle start");
        settle_rest(512, 3'b100, "R6 settle n=0");

        // immediate mode
        do_write(1'b1, 2'b01, 3'd1);
        expect_out(3'b010, 1'b1, 1'b1, "R8 immediate x2");
        do_write(1'b1, 2'b11, 3'd1);
        expect_out(3'b010, 1'b1, 1'b1, "R2 reserved immediate ignored");
        do_write(1'b1, 2'b00, 3'd1);
        expect_out(3'b001, 1'b1, 1'b1, "R8 immediate x1");
        do_write(1'b0, 2'b10, 3'd1);
        expect_out(3'b001, 1'b1, 1'b1, "R3 deferred after immediate");

        // wake in the same cycle as the request: must not be lost
        sby_req = 1'b1;
        wake = 1'b1;
        tick();
        sby_req = 1'b0;
        wake = 1'b0;
        expect_out(3'b001, 1'b0, 1'b0, "R9 gated with early wake");
        tick();
        expect_out(3'b100, 1'b0, 1'b0, "R5 applied after gate");
        tick();
        expect_out(3'b100, 1'b0, 1'b0, "R9 settle started");
        settle_rest(1024, 3'b100, "R9 early wake, settle n=1 (R6)");

        // wake while running has no effect
        wake = 1'b1;
        tick();
        wake = 1'b0;
        tick();
        expect_out(3'b100, 1'b1, 1'b1, "R7 ready stays high running");

        repeat (2) tick();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL R6 watchdog: actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule